// File: doc/BRIEF.md
# Protected Watchdog Timer

This block is a watchdog counter with two byte-wide registers on a small memory-mapped bus. The mode register sets the overflow period and may stop the watchdog. The restart register takes a fixed key that clears the counter. If the counter reaches the selected count, the block raises a one-cycle internal reset request. Software must write the restart key at regular intervals to prevent this.

Both registers are protected. The mode register can be written once after reset, using a byte write. A second byte write to it raises a reset request. A wrong restart key raises a reset request, and so does any single-bit write to the restart register. The source-clock enable input tells the block whether the watchdog clock is running. While that clock is stopped the counter holds its value. A reset request caused by misuse in that time is held and is issued on the first cycle after the clock resumes. A configuration input decides whether software may stop the watchdog. Once software stops it, the stop lasts until the next hard reset.

Top module: `wdog_guard`

## Requirements
- R1: After reset, the first byte write to the mode address (`MODE_ADDR`, default 0x8) is accepted without a reset request. Every later byte write to that address produces one reset pulse and leaves the mode register unchanged.
- R2: A single-bit write (`bus_bitop`=1) to the mode address changes nothing and produces no reset pulse. It does not use up the one permitted byte write.
- R3: Layout of the mode register:
  - Bits [2:0] select the period.
  - Bit 4 is the stop bit.
  - Bit 3 always reads 0.
  - Bits [7:5] always read 011, whatever value was written.
  - The reset value reads as 0x67.
- R4: The stop bit acts only when `may_stop`=1. If it is then written as 1, counting stops until `rst_n`. After that, no overflow produces a reset request, and neither does a later write to either register. If `may_stop`=0, the written stop bit is ignored and reads back as 0.
- R5: A byte write of the key 0xAC to the restart address (`KICK_ADDR`, default 0x9) clears the counter to zero. The next overflow then needs a full period. A key write on the cycle that would overflow prevents that overflow's reset request.
- R6: A byte write of any value other than 0xAC to the restart address produces a reset pulse.
- R7: A single-bit write to the restart address produces a reset pulse, whatever the data.
- R8: Reads return these values:
  - The restart address always reads 0x9A.
  - Any address other than the two registers reads 0x00.
- R9: While `src_clk_en`=0 the counter holds its value. A reset request caused by misuse in that time is held pending and is issued on the first clock edge at which `src_clk_en`=1.
- R10: The overflow period is 2^(MIN_EXP+sel) counting cycles, where sel is mode bits [2:0]. After reset, sel is 7 until the mode register is written. Overflows repeat at that period.
- R11: `rst_req` goes high for exactly one cycle per event. It is registered, so it is high in the cycle after the clock edge that sampled the triggering access or overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| src_clk_en | input | 1 | High while the watchdog source clock runs |
| may_stop | input | 1 | 1 allows software to stop the watchdog |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_bitop | input | 1 | Marks the write as a single-bit access |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| rst_req | output | 1 | One-cycle internal reset request |

## Verification
The period is checked at both exact edges. A counter that starts one count off, or that does not clear on a key write, moves the reset pulse by one or more cycles, and the pulse is compared in the exact cycle both before and after the expected edge. A lost or duplicated pending request shows up as a missing or second pulse on the first cycle after the source clock resumes. A stop flag that clears, or a one-time-write flag that is never set, shows at the ports within one period: a pulse appears where none is allowed, or a second mode write is accepted silently.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int          SEL_W     = 3;
    localparam logic [7:0]  KICK_KEY  = 8'hAC;
    localparam logic [7:0]  KICK_READ = 8'h9A;
    localparam logic [2:0]  MODE_TOP  = 3'b011;

    typedef struct packed {
        logic             written;
        logic             halted;
        logic [SEL_W-1:0] sel;
    } mode_state_t;

    typedef struct packed {
        logic pending;
        logic pulse;
    } req_state_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int              ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] MODE_ADDR = 4'h8,
    parameter logic [ADDR_W-1:0] KICK_ADDR = 4'h9,
    parameter int              DEF_SEL   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              may_stop,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_bitop,
    output logic [SEL_W-1:0]  sel,
    output logic              halted,
    output logic              kick,
    output logic              illegal,
    output logic [7:0]        bus_rdata
);
    mode_state_t st_d, st_q;
    logic        mode_hit, kick_hit;
    logic        wdata_unused;

    // bits 7:5 and 3 of a mode write carry no function
    assign wdata_unused = &{1'b0, bus_wdata[7:5], bus_wdata[3]};

    always_comb begin
        st_d     = st_q;
        kick     = 1'b0;
        illegal  = 1'b0;
        mode_hit = bus_we && (bus_addr == MODE_ADDR);
        kick_hit = bus_we && (bus_addr == KICK_ADDR);
        if (mode_hit && !bus_bitop) begin
            if (st_q.written) begin
                illegal = 1'b1;
            end else begin
                st_d.written = 1'b1;
                st_d.halted  = may_stop & bus_wdata[4];
                st_d.sel     = bus_wdata[SEL_W-1:0];
            end
        end
        if (kick_hit) begin
            if (bus_bitop || (bus_wdata != KICK_KEY)) illegal = 1'b1;
            else                                      kick    = 1'b1;
        end
    end

    always_comb begin
        if (bus_addr == MODE_ADDR)      bus_rdata = {MODE_TOP, st_q.halted, 1'b0, st_q.sel};
        else if (bus_addr == KICK_ADDR) bus_rdata = KICK_READ;
        else                            bus_rdata = 8'h00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{written: 1'b0, halted: 1'b0, sel: SEL_W'(DEF_SEL)};
        else        st_q <= st_d;
    end

    assign sel    = st_q.sel;
    assign halted = st_q.halted;
endmodule

// File: rtl/wdog_count.sv
module wdog_count
    import wdog_pkg::*;
#(
    parameter int MIN_EXP = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             kick,
    input  logic [SEL_W-1:0] sel,
    output logic             wrap
);
    localparam int CNT_W = MIN_EXP + (1 << SEL_W) - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t       st_d, st_q;
    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] last;

    always_comb begin
        span = (CNT_W+1)'(1) << (MIN_EXP + int'(sel));
        last = span[CNT_W-1:0] - CNT_W'(1);
        st_d = st_q;
        wrap = 1'b0;
        if (kick) begin
            st_d.cnt = '0;
        end else if (run) begin
            if (st_q.cnt == last) begin
                st_d.cnt = '0;
                wrap     = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: '0};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
    import wdog_pkg::*;
#(
    parameter int                ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] MODE_ADDR = 4'h8,
    parameter logic [ADDR_W-1:0] KICK_ADDR = 4'h9,
    parameter int                MIN_EXP   = 10,
    parameter int                DEF_SEL   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_clk_en,
    input  logic              may_stop,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_bitop,
    output logic [7:0]        bus_rdata,
    output logic              rst_req
);
    logic [SEL_W-1:0] sel;
    logic             halted, kick, illegal, wrap, run;
    req_state_t       rq_d, rq_q;

    wdog_regs #(
        .ADDR_W(ADDR_W), .MODE_ADDR(MODE_ADDR), .KICK_ADDR(KICK_ADDR), .DEF_SEL(DEF_SEL)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .may_stop(may_stop), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_bitop(bus_bitop),
        .sel(sel), .halted(halted), .kick(kick), .illegal(illegal), .bus_rdata(bus_rdata)
    );

    // a software stop looks like a source clock that never comes back
    assign run = src_clk_en & ~halted;

    wdog_count #(.MIN_EXP(MIN_EXP)) u_count (
        .clk(clk), .rst_n(rst_n), .run(run), .kick(kick), .sel(sel), .wrap(wrap)
    );

    always_comb begin
        rq_d.pending = rq_q.pending | illegal;
        rq_d.pulse   = 1'b0;
        if (run) begin
            rq_d.pulse   = rq_d.pending | wrap;
            rq_d.pending = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rq_q <= '{pending: 1'b0, pulse: 1'b0};
        else        rq_q <= rq_d;
    end

    assign rst_req = rq_q.pulse;
endmodule

// File: rtl/wdog_guard_chk.sv
module wdog_guard_chk
    import wdog_pkg::*;
#(
    parameter int                ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] MODE_ADDR = 4'h8,
    parameter logic [ADDR_W-1:0] KICK_ADDR = 4'h9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              src_clk_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [7:0]        bus_wdata,
    input logic              bus_bitop,
    input logic [7:0]        bus_rdata,
    input logic              rst_req,
    input logic              halted
);
    // R11
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R9
    frozen_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !src_clk_en |=> !rst_req);

    // R8
    kick_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == KICK_ADDR) |-> (bus_rdata == KICK_READ));

    // R3
    mode_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == MODE_ADDR) |-> (bus_rdata[7:5] == MODE_TOP && !bus_rdata[3]));

    // R6
    bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == KICK_ADDR && !bus_bitop && bus_wdata != KICK_KEY
         && src_clk_en && !halted) |=> rst_req);

    // R4
    stop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);
endmodule

bind wdog_guard wdog_guard_chk #(
    .ADDR_W(ADDR_W), .MODE_ADDR(MODE_ADDR), .KICK_ADDR(KICK_ADDR)
) u_wdog_guard_chk (
    .clk(clk), .rst_n(rst_n), .src_clk_en(src_clk_en), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_bitop(bus_bitop),
    .bus_rdata(bus_rdata), .rst_req(rst_req), .halted(halted)
);

// File: tb/wdog_guard_bench.sv
module wdog_guard_bench;
    localparam logic [3:0] MA = 4'h8;
    localparam logic [3:0] KA = 4'h9;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       src_clk_en = 1'b1;
    logic       may_stop = 1'b0;
    logic [3:0] bus_addr = 4'h0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_bitop = 1'b0;
    logic [7:0] bus_rdata;
    logic       rst_req;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    wdog_guard #(.MIN_EXP(4)) u_wdog_guard (
        .clk(clk), .rst_n(rst_n), .src_clk_en(src_clk_en), .may_stop(may_stop),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_bitop(bus_bitop), .bus_rdata(bus_rdata), .rst_req(rst_req)
    );

    typedef struct packed {
        logic [7:0] data;
        logic       bitop;
        logic       exp;
    } row_t;

    localparam row_t ROWS [8] = '{
        '{8'hAC, 1'b0, 1'b0}, '{8'h00, 1'b0, 1'b1}, '{8'hAB, 1'b0, 1'b1},
        '{8'hAD, 1'b0, 1'b1}, '{8'h9A, 1'b0, 1'b1}, '{8'h2C, 1'b0, 1'b1},
        '{8'hAC, 1'b1, 1'b1}, '{8'hFF, 1'b1, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d, input logic b);
        bus_addr = a; bus_wdata = d; bus_bitop = b; bus_we = 1'b1;
        tick();
        bus_we = 1'b0; bus_bitop = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulses(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            tick();
            if (rst_req) c++;
        end
    endtask

    task automatic hard_reset(input logic stop_ok);
        may_stop = stop_ok;
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int c;
        hard_reset(1'b0);
        chk("R11 idle after reset", rst_req, 0);
        rd(KA, v); chk("R8 restart reads 9A", v, 8'h9A);
        rd(MA, v); chk("R3 mode reset value", v, 8'h67);
        rd(4'h3, v); chk("R8 unmapped reads 0", v, 8'h00);

        // R5 R6 R7: restart-register vectors
        foreach (ROWS[i]) begin
            wr(KA, ROWS[i].data, ROWS[i].bitop);
            chk("R6/R7 restart write response", rst_req, ROWS[i].exp);
            tick();
            chk("R11 single cycle", rst_req, 0);
        end
        rd(KA, v); chk("R8 reads 9A after key", v, 8'h9A);

        // R10 default period 2^(4+7)
        wr(KA, 8'hAC, 1'b0);
        pulses(2047, c); chk("R10 no early default overflow", c, 0);
        tick(); chk("R10 default overflow", rst_req, 1);
        tick(); chk("R11 overflow pulse single", rst_req, 0);

        // R1 first mode write, sel 0 -> 16
        wr(MA, 8'h60, 1'b0); chk("R1 first mode write quiet", rst_req, 0);
        rd(MA, v); chk("R1 mode stored", v, 8'h60);
        wr(KA, 8'hAC, 1'b0);
        pulses(15, c); chk("R10 no early overflow", c, 0);
        tick(); chk("R10 overflow at 16", rst_req, 1);
        pulses(48, c); chk("R10 repeats", c, 3);

        // R5 key on the overflow cycle
        wr(KA, 8'hAC, 1'b0);
        pulses(15, c);
        wr(KA, 8'hAC, 1'b0); chk("R5 late key suppresses", rst_req, 0);
        pulses(15, c); chk("R5 counter cleared", c, 0);
        tick(); chk("R5 full period after key", rst_req, 1);

        // R1 second mode write
        wr(KA, 8'hAC, 1'b0);
        wr(MA, 8'h67, 1'b0); chk("R1 second write resets", rst_req, 1);
        tick(); chk("R11 single", rst_req, 0);
        rd(MA, v); chk("R1 mode unchanged", v, 8'h60);

        // R9 deferred request
        wr(KA, 8'hAC, 1'b0);
        src_clk_en = 1'b0;
        wr(KA, 8'h55, 1'b0); chk("R9 held while stopped", rst_req, 0);
        pulses(20, c); chk("R9 nothing while stopped", c, 0);
        src_clk_en = 1'b1;
        tick(); chk("R9 issued on resume", rst_req, 1);
        tick(); chk("R9 issued once", rst_req, 0);
        pulses(13, c); chk("R9 counter was frozen", c, 0);
        tick(); chk("R9 overflow after resume", rst_req, 1);

        // R2 R3 R4 with stop forbidden
        hard_reset(1'b0);
        wr(MA, 8'h61, 1'b1); chk("R2 bit write quiet", rst_req, 0);
        rd(MA, v); chk("R2 bit write no change", v, 8'h67);
        wr(MA, 8'h11, 1'b0); chk("R2 byte write still allowed", rst_req, 0);
        rd(MA, v); chk("R3/R4 top bits and stop ignored", v, 8'h61);
        wr(KA, 8'hAC, 1'b0);
        pulses(31, c); chk("R4 still counting", c, 0);
        tick(); chk("R4 overflow at 32", rst_req, 1);

        // R4 software stop
        hard_reset(1'b1);
        wr(MA, 8'h70, 1'b0); chk("R4 stop write quiet", rst_req, 0);
        rd(MA, v); chk("R4 stop reads back", v, 8'h70);
        pulses(2100, c); chk("R4 halted no overflow", c, 0);
        wr(MA, 8'h60, 1'b0); chk("R4 later write no reset", rst_req, 0);
        rd(MA, v); chk("R4 stop not undone", v, 8'h70);
        wr(KA, 8'h00, 1'b0);
        pulses(2100, c); chk("R4 still halted", c, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule